// File: doc/BRIEF.md
# Multi-Port Memory Request Arbiter

This block sits in front of a DRAM controller and merges the requests of four host ports into a single downstream request stream. Each host port has a read channel and a write channel, so the arbiter has eight request sources. Each source has its own small request queue with a valid/ready handshake on its input side. Reads and writes leave the block over the same output interface, one request per grant, tagged with the index of the source and a read/write flag.

In each cycle in which the downstream side is ready, the arbiter grants the head of one non-empty queue. Three factors decide the winner. A per-port urgency input comes first. Next comes whether the request falls in the same DRAM row as the previously granted request. Next comes how long the request has waited, counted by a saturating age counter per source. The lowest source index settles any remaining tie. The granted request is placed in a registered output stage that holds its payload until the downstream side accepts it.

Top module: `mem_req_arbiter`

## Requirements
- R1: After reset, out_valid is 0, every in_ready bit is 1, and no request counts as a row hit until the first grant has been made (the stored row starts empty, so a request whose row field is 0 gets no hit).
- R2: Each source index i has a first-in first-out queue of QDEPTH entries (default 4). in_ready[i] is 0 while that queue is full, and a request offered while in_ready[i] is 0 is dropped. Requests from one source leave the block in the order they were accepted.
- R3: A grant is made only in a cycle in which out_ready is 1 and at least one queue is non-empty. The granted request appears on the output, with out_valid at 1, after the next rising clock edge. While out_ready is 0, out_valid stays 0 when it is already 0.
- R4: While out_valid is 1 and out_ready is 0, out_valid, out_addr, out_port and out_is_write keep their values.
- R5: Each source has an age counter. The counter rises by one for every cycle in which that source's queue head waits without a grant, and it stops at 15. The counter is cleared on a grant to that source and while the queue is empty. When no request is urgent and none is a row hit, the oldest head wins, and two heads that have both reached 15 count as equal.
- R6: The row of an address is out_addr[ROW_LSB +: ROW_W] (default bits 26:13). A head whose row equals the row of the last granted request is a row hit. A row hit wins over any non-hit of the same urgency, whatever the ages.
- R7: A head whose source has in_urgent set at the time of arbitration wins over every non-urgent head, whatever the row hit and age.
- R8: When the best scores are equal, the source with the lowest index wins.
- R9: Source indices 0 to 3 are the read channels of host ports 0 to 3, and indices 4 to 7 are the write channels. out_port carries the source index, and out_is_write is 1 exactly when out_port is 4 or higher.
- R10: At most one queue is popped per cycle. A request held on the output is consumed in the cycle with out_valid and out_ready both at 1, and in that same cycle the next grant, if there is one, replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 2*NUM_HOST | Request offered, one bit per source |
| in_ready | output | 2*NUM_HOST | Source queue can accept a request |
| in_addr | input | 2*NUM_HOST*ADDR_W | Request addresses; source i uses bits [i*ADDR_W +: ADDR_W] |
| in_urgent | input | 2*NUM_HOST | Urgency level, one bit per source |
| out_valid | output | 1 | Granted request present on output |
| out_ready | input | 1 | Downstream controller accepts a request |
| out_addr | output | ADDR_W | Address of the granted request |
| out_is_write | output | 1 | 1 for a write channel, 0 for a read channel |
| out_port | output | $clog2(2*NUM_HOST) | Source index of the granted request |

## Verification
The hardest situation to reach from the ports is the one where two heads have waited longer than the age counter can count. Age saturation leaves no trace on any output until it changes which source wins. The bench holds out_ready low, queues a high-index source, queues a lower-index source a few cycles later, and then waits well past 15 cycles. When it releases out_ready, the younger lower-index request must win, because both ages have stopped at 15. The other ordering rules are reached the same way: queues are preloaded under back-pressure, with arrival times and row fields chosen so that only one factor separates the contenders.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Direction of a request source: lower half reads, upper half writes.
  typedef enum logic {
    KIND_READ  = 1'b0,
    KIND_WRITE = 1'b1
  } req_kind_e;

  // Saturation limit of an AGE_W-bit counter.
  function automatic int unsigned age_limit(input int unsigned age_w);
    return (1 << age_w) - 1;
  endfunction

endpackage

// File: rtl/arb_req_queue.sv
module arb_req_queue #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         can_push,
  input  logic         pop,
  output logic         head_valid,
  output logic [W-1:0] head_data
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] count;
  logic          do_push;
  logic          do_pop;

  assign can_push   = (count != CW'(DEPTH));
  assign head_valid = (count != '0);
  assign head_data  = mem[rd_ptr];
  assign do_push    = push && can_push;
  assign do_pop     = pop && head_valid;

  // Storage array without reset so it maps onto distributed or block memory.
  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (do_pop) begin
        rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/arb_age_ctr.sv
module arb_age_ctr
  import arb_pkg::*;
#(
  parameter int AGE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pending,
  input  logic             granted,
  output logic [AGE_W-1:0] age
);

  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(age_limit(AGE_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      age <= '0;
    end else if (!pending || granted) begin
      age <= '0;
    end else if (age != AGE_MAX) begin
      age <= age + 1'b1;
    end
  end

endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N       = 8,
  parameter int SCORE_W = 6,
  localparam int IDX_W  = $clog2(N)
) (
  input  logic [N-1:0]         cand,
  input  logic [N*SCORE_W-1:0] score_flat,
  output logic                 any,
  output logic [IDX_W-1:0]     idx
);

  logic [SCORE_W-1:0] best;

  // Scan from the top index down; ">=" lets a lower index take over on a tie.
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i] && (!any || score_flat[i*SCORE_W +: SCORE_W] >= best)) begin
        any  = 1'b1;
        idx  = IDX_W'(i);
        best = score_flat[i*SCORE_W +: SCORE_W];
      end
    end
  end

endmodule

// File: rtl/mem_req_arbiter.sv
module mem_req_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_HOST = 4,
  parameter int ADDR_W   = 32,
  parameter int QDEPTH   = 4,
  parameter int AGE_W    = 4,
  parameter int ROW_LSB  = 13,
  parameter int ROW_W    = 14
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [2*NUM_HOST-1:0]          in_valid,
  output logic [2*NUM_HOST-1:0]          in_ready,
  input  logic [2*NUM_HOST*ADDR_W-1:0]   in_addr,
  input  logic [2*NUM_HOST-1:0]          in_urgent,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [ADDR_W-1:0]              out_addr,
  output logic                           out_is_write,
  output logic [$clog2(2*NUM_HOST)-1:0]  out_port
);

  localparam int NUM_PORTS = 2 * NUM_HOST;
  localparam int PORT_W    = $clog2(NUM_PORTS);
  localparam int SCORE_W   = AGE_W + 2;

  logic [NUM_PORTS-1:0]         head_valid;
  logic [NUM_PORTS-1:0]         pop;
  logic [NUM_PORTS-1:0]         row_hit;
  logic [ADDR_W-1:0]            head_addr [NUM_PORTS];
  logic [NUM_PORTS*AGE_W-1:0]   age_flat;
  logic [NUM_PORTS*SCORE_W-1:0] score_flat;
  logic [ROW_W-1:0]             last_row;
  logic                         last_row_valid;
  logic                         pick_any;
  logic [PORT_W-1:0]            pick_idx;
  logic                         grant;
  logic [ADDR_W-1:0]            sel_addr;
  req_kind_e                    sel_kind;

  genvar g;
  generate
    for (g = 0; g < NUM_PORTS; g++) begin : g_src
      arb_req_queue #(
        .W     (ADDR_W),
        .DEPTH (QDEPTH)
      ) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push       (in_valid[g]),
        .push_data  (in_addr[g*ADDR_W +: ADDR_W]),
        .can_push   (in_ready[g]),
        .pop        (pop[g]),
        .head_valid (head_valid[g]),
        .head_data  (head_addr[g])
      );

      arb_age_ctr #(
        .AGE_W (AGE_W)
      ) u_age (
        .clk     (clk),
        .rst     (rst),
        .pending (head_valid[g]),
        .granted (pop[g]),
        .age     (age_flat[g*AGE_W +: AGE_W])
      );

      assign row_hit[g] = last_row_valid &&
                          (head_addr[g][ROW_LSB +: ROW_W] == last_row);

      // Score order: urgency, then row hit, then age.
      assign score_flat[g*SCORE_W +: SCORE_W] =
          {in_urgent[g], row_hit[g], age_flat[g*AGE_W +: AGE_W]};

      assign pop[g] = grant && (pick_idx == PORT_W'(g));
    end
  endgenerate

  arb_pick #(
    .N       (NUM_PORTS),
    .SCORE_W (SCORE_W)
  ) u_pick (
    .cand       (head_valid),
    .score_flat (score_flat),
    .any        (pick_any),
    .idx        (pick_idx)
  );

  assign grant = out_ready && pick_any;

  always_comb begin
    sel_addr = head_addr[pick_idx];
    sel_kind = (32'(pick_idx) >= NUM_HOST) ? KIND_WRITE : KIND_READ;
  end

  // Registered output stage; it reloads only when downstream is ready.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_addr       <= '0;
      out_is_write   <= 1'b0;
      out_port       <= '0;
      last_row       <= '0;
      last_row_valid <= 1'b0;
    end else if (grant) begin
      out_valid      <= 1'b1;
      out_addr       <= sel_addr;
      out_is_write   <= (sel_kind == KIND_WRITE);
      out_port       <= pick_idx;
      last_row       <= sel_addr[ROW_LSB +: ROW_W];
      last_row_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid      <= 1'b0;
    end
  end

endmodule

// File: rtl/arb_checker.sv
module arb_checker
  import arb_pkg::*;
#(
  parameter int NUM_HOST = 4,
  parameter int ADDR_W   = 32,
  parameter int AGE_W    = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          out_valid,
  input logic                          out_ready,
  input logic [ADDR_W-1:0]             out_addr,
  input logic                          out_is_write,
  input logic [$clog2(2*NUM_HOST)-1:0] out_port,
  input logic [2*NUM_HOST-1:0]         in_urgent,
  input logic [2*NUM_HOST-1:0]         in_ready,
  input logic [2*NUM_HOST-1:0]         head_valid,
  input logic [2*NUM_HOST-1:0]         pop,
  input logic [2*NUM_HOST*AGE_W-1:0]   age_flat
);

  localparam int NUM_PORTS = 2 * NUM_HOST;
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(age_limit(AGE_W));

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) &&
                                $stable(out_port) && $stable(out_is_write));

  assert_no_fwd_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !out_valid && !out_ready |=> !out_valid);

  assert_pop_needs_ready_R3: assert property (@(posedge clk) disable iff (rst)
    (|pop) |-> out_ready);

  assert_single_pop_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pop));

  assert_pop_loads_out_R10: assert property (@(posedge clk) disable iff (rst)
    (|pop) |=> out_valid);

  assert_kind_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_is_write == (32'(out_port) >= NUM_HOST)));

  assert_urgent_first_R7: assert property (@(posedge clk) disable iff (rst)
    (|pop) && (|(in_urgent & head_valid)) |-> (|(pop & in_urgent)));

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_port
      assert_age_step_R5: assert property (@(posedge clk) disable iff (rst)
        head_valid[p] && !pop[p] && (age_flat[p*AGE_W +: AGE_W] != AGE_MAX)
        |=> age_flat[p*AGE_W +: AGE_W] == $past(age_flat[p*AGE_W +: AGE_W]) + 1'b1);

      assert_age_clear_R5: assert property (@(posedge clk) disable iff (rst)
        pop[p] |=> age_flat[p*AGE_W +: AGE_W] == '0);

      assert_full_has_head_R2: assert property (@(posedge clk) disable iff (rst)
        !in_ready[p] |-> head_valid[p]);
    end
  endgenerate

endmodule

bind mem_req_arbiter arb_checker #(
  .NUM_HOST (NUM_HOST),
  .ADDR_W   (ADDR_W),
  .AGE_W    (AGE_W)
) u_arb_checker (
  .clk          (clk),
  .rst          (rst),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_addr     (out_addr),
  .out_is_write (out_is_write),
  .out_port     (out_port),
  .in_urgent    (in_urgent),
  .in_ready     (in_ready),
  .head_valid   (head_valid),
  .pop          (pop),
  .age_flat     (age_flat)
);

// File: tb/tb_mem_req_arbiter.sv
module tb_mem_req_arbiter;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  in_valid;
  logic [7:0]  in_ready;
  logic [255:0] in_addr;
  logic [7:0]  in_urgent;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_addr;
  logic        out_is_write;
  logic [2:0]  out_port;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  mem_req_arbiter dut (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_addr      (in_addr),
    .in_urgent    (in_urgent),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_addr     (out_addr),
    .out_is_write (out_is_write),
    .out_port     (out_port)
  );

  function automatic logic [31:0] mk_addr(input int row, input int col);
    return (32'(row) << 13) | 32'(col & 32'h1fff);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic push(input int p, input logic [31:0] a);
    in_valid[p] = 1'b1;
    in_addr[p*32 +: 32] = a;
    step(1);
    in_valid[p] = 1'b0;
  endtask

  task automatic push2(input int p, input logic [31:0] a, input int q, input logic [31:0] b);
    in_valid[p] = 1'b1;
    in_addr[p*32 +: 32] = a;
    in_valid[q] = 1'b1;
    in_addr[q*32 +: 32] = b;
    step(1);
    in_valid[p] = 1'b0;
    in_valid[q] = 1'b0;
  endtask

  task automatic expect_out(input bit v, input int port, input int row, input string req);
    chk(out_valid == v, {req, " out_valid"}, int'(out_valid), int'(v));
    if (v) begin
      chk(out_port == 3'(port), {req, " out_port"}, int'(out_port), port);
      chk(out_addr[26:13] == 14'(row), {req, " row"}, int'(out_addr[26:13]), row);
      chk(out_is_write == (port >= 4), "R9 out_is_write", int'(out_is_write), int'(port >= 4));
    end
  endtask

  task automatic test_reset();
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 8'hff, "R1 in_ready after reset", int'(in_ready), 255);
    // Row 0 must not count as a hit before any grant: older port 2 wins.
    push(2, mk_addr(5, 1));
    push(5, mk_addr(0, 2));
    out_ready = 1'b1;
    step(1); expect_out(1, 2, 5, "R1 no hit before first grant");
    step(1); expect_out(1, 5, 0, "R1 second grant");
    step(1); expect_out(0, 0, 0, "R10 drained");
    out_ready = 1'b0;
  endtask

  task automatic test_age();
    push(6, mk_addr(10, 0));
    step(3);
    push(1, mk_addr(11, 0));
    expect_out(0, 0, 0, "R3 no forward while out_ready low");
    step(2);
    expect_out(0, 0, 0, "R3 still idle with out_ready low");
    out_ready = 1'b1;
    step(1); expect_out(1, 6, 10, "R5 older request wins");
    step(1); expect_out(1, 1, 11, "R5 younger request next");
    step(1); expect_out(0, 0, 0, "R10 drained");
    out_ready = 1'b0;
  endtask

  task automatic test_hit();
    // Last granted row is 11.
    push(0, mk_addr(20, 0));
    step(3);
    push(3, mk_addr(11, 7));
    out_ready = 1'b1;
    step(1); expect_out(1, 3, 11, "R6 row hit beats age");
    step(1); expect_out(1, 0, 20, "R6 non-hit follows");
    step(1); expect_out(0, 0, 0, "R10 drained");
    out_ready = 1'b0;
  endtask

  task automatic test_urgent();
    // Last row is 20: port 2 is an older row hit, port 7 is urgent.
    push(2, mk_addr(20, 3));
    step(2);
    in_urgent[7] = 1'b1;
    push(7, mk_addr(30, 0));
    out_ready = 1'b1;
    step(1); expect_out(1, 7, 30, "R7 urgent beats hit and age");
    in_urgent[7] = 1'b0;
    step(1); expect_out(1, 2, 20, "R7 non-urgent follows");
    step(1); expect_out(0, 0, 0, "R10 drained");
    out_ready = 1'b0;
  endtask

  task automatic test_tie();
    push2(5, mk_addr(40, 0), 4, mk_addr(41, 0));
    out_ready = 1'b1;
    step(1); expect_out(1, 4, 41, "R8 lowest index on tie");
    step(1); expect_out(1, 5, 40, "R8 higher index next");
    step(1); expect_out(0, 0, 0, "R10 drained");
    out_ready = 1'b0;
  endtask

  task automatic test_saturate();
    push(6, mk_addr(50, 0));
    step(3);
    push(3, mk_addr(51, 0));
    step(20);
    out_ready = 1'b1;
    step(1); expect_out(1, 3, 51, "R5 saturated ages tie, lower index wins");
    step(1); expect_out(1, 6, 50, "R5 older saturated request next");
    step(1); expect_out(0, 0, 0, "R10 drained");
    out_ready = 1'b0;
  endtask

  task automatic test_stall();
    push2(1, mk_addr(60, 0), 2, mk_addr(61, 0));
    out_ready = 1'b1;
    step(1); expect_out(1, 1, 60, "R3 grant with out_ready");
    out_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step(1); expect_out(1, 1, 60, "R4 held while out_ready low");
    end
    out_ready = 1'b1;
    step(1); expect_out(1, 2, 61, "R10 consumed and replaced");
    out_ready = 1'b0;
    step(2); expect_out(1, 2, 61, "R4 second hold");
    out_ready = 1'b1;
    step(1); expect_out(0, 0, 0, "R10 consumed, nothing left");
    out_ready = 1'b0;
  endtask

  task automatic test_fifo();
    for (int k = 0; k < 4; k++) begin
      push(0, mk_addr(70 + k, k));
    end
    chk(in_ready[0] == 1'b0, "R2 in_ready low when full", int'(in_ready[0]), 0);
    chk(in_ready[1] == 1'b1, "R2 other queue unaffected", int'(in_ready[1]), 1);
    push(0, mk_addr(99, 0));
    out_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step(1); expect_out(1, 0, 70 + k, "R2 queue order");
    end
    step(1); expect_out(0, 0, 0, "R2 request offered while full dropped");
    chk(in_ready[0] == 1'b1, "R2 in_ready back high", int'(in_ready[0]), 1);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst       = 1'b1;
    in_valid  = '0;
    in_addr   = '0;
    in_urgent = '0;
    out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step(1);
    test_reset();
    test_age();
    test_hit();
    test_urgent();
    test_tie();
    test_saturate();
    test_stall();
    test_fifo();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule